// File: doc/BRIEF.md
# Multi-Channel Countdown Timer Bank

This block holds a configurable number of independent down-counters behind a single-cycle APB slave port. Each channel has four registers. The load register holds the start and reload value. The value register returns the live count. The control register holds the enable, mode and mask bits. The clear register acknowledges the channel's interrupt when it is read. Two shared registers follow the channel array: one shows the raw expiry status of every channel, the other shows that status after masking.

Software writes a start value while a channel is stopped, then sets its enable bit. From then on the counter steps down by one every clock. When it has sat at zero for a cycle it reloads. In free-running mode it reloads all ones. In periodic mode it reloads the load register. The same edge records a pending expiry. Each channel drives a registered interrupt line that follows the pending bit unless the channel is masked.

Top module: `apb_countdown_bank`

## Requirements
- R1: After the synchronous reset, every register reads zero, every interrupt line is low and the read data bus is zero.
- R2: A write to the control register that changes enable (bit 0) from 0 to 1 loads the counter from the load register (channel offset 0x0). While the channel is enabled, the counter (read at offset 0x4) drops by one each clock while it is not zero.
- R3: When control bit 1 is 0 (free-running) and the counter is zero while enabled, the next edge loads 0xFFFFFFFF.
- R4: When control bit 1 is 1 (periodic) and the counter is zero while enabled, the next edge reloads the load register, which gives a period of load+1 clocks.
- R5: The edge that reloads an expired channel sets that channel's pending bit. The raw status register (shared offset +0x4) shows channel n's pending bit at bit n.
- R6: When control bit 2 (mask) is 1, the channel's interrupt line stays low, but its pending bit still sets. The masked status register (shared offset +0x0) reads raw AND NOT mask.
- R7: Each interrupt line is a register that equals the channel's pending bit AND NOT its mask, as they stood one clock earlier.
- R8: A read of a channel's clear register (offset 0xC) returns the pending bit in bit 0 and clears that bit. It changes neither the count nor the control register. An expiry in the same cycle wins over the clear.
- R9: Clearing enable freezes the counter and leaves the pending bit as it is.
- R10: A write to the load register while the channel is enabled does not change the running count. The new value is used at the next reload.
- R11: pready is always high. A read of an undefined, misaligned or out-of-window address returns zero. Writes to read-only or undefined addresses change nothing.
- R12: Channel n's registers sit at n*16, and the shared registers start at NCH*16. An access to one channel changes no other channel.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write when high |
| paddr | input | 32 | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data, captured in the setup phase |
| pready | output | 1 | Always high |
| irq | output | NCH | Per-channel interrupt lines |

## Verification
The bound checker watches every channel on every cycle. It checks the one-per-clock decrement, the freeze while disabled, that a pending bit rises only after the counter sat at zero while enabled, that a pending bit falls only after a clear read, and that each interrupt line is the delayed pending-and-unmasked value and is never high under a mask. Some behaviour is only visible in the bench's scripted register sequences: the two reload values, the late effect of a load write made while running, the zero result of undefined addresses, and the isolation between channels.

// File: rtl/cdt_pkg.sv
package cdt_pkg;

  // byte distance between consecutive channel register groups
  localparam int unsigned CH_STRIDE = 16;

  // word select inside one channel group (address bits [3:2])
  typedef enum logic [1:0] {
    SEL_LOAD  = 2'd0,
    SEL_VALUE = 2'd1,
    SEL_CTRL  = 2'd2,
    SEL_CLEAR = 2'd3
  } chan_sel_e;

  // shared register offsets relative to the end of the channel array
  localparam int unsigned SH_MASKED = 0;
  localparam int unsigned SH_RAW    = 4;

  // control word, bit 0 = enable, bit 1 = periodic, bit 2 = mask
  typedef struct packed {
    logic mask;
    logic periodic;
    logic enable;
  } ctrl_t;

endpackage

// File: rtl/cdt_channel.sv
module cdt_channel
  import cdt_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_load,
  input  logic             wr_ctrl,
  input  logic [31:0]      wdata,
  input  logic             clr_rd,
  output logic [CNT_W-1:0] load_q,
  output logic [CNT_W-1:0] cnt_q,
  output ctrl_t            ctrl_q,
  output logic             pend_q,
  output logic             irq_q
);

  localparam logic [CNT_W-1:0] ALL_ONES = '1;

  ctrl_t ctrl_new;
  logic  start;
  logic  expire;

  always_comb begin
    ctrl_new = ctrl_t'(wdata[2:0]);
    start    = wr_ctrl && ctrl_new.enable && !ctrl_q.enable;
    expire   = ctrl_q.enable && (cnt_q == '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      load_q <= '0;
      cnt_q  <= '0;
      ctrl_q <= '0;
      pend_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      if (wr_load) load_q <= wdata[CNT_W-1:0];
      if (wr_ctrl) ctrl_q <= ctrl_new;

      if (start) begin
        cnt_q <= load_q;
      end else if (ctrl_q.enable) begin
        if (expire) cnt_q <= ctrl_q.periodic ? load_q : ALL_ONES;
        else        cnt_q <= cnt_q - 1'b1;
      end

      // a new expiry outranks a clear in the same cycle
      if (expire)      pend_q <= 1'b1;
      else if (clr_rd) pend_q <= 1'b0;

      irq_q <= pend_q && !ctrl_q.mask;
    end
  end

endmodule

// File: rtl/cdt_apb_decode.sv
module cdt_apb_decode
  import cdt_pkg::*;
#(
  parameter int unsigned NCH   = 8,
  parameter int unsigned CNT_W = 32
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       psel,
  input  logic                       penable,
  input  logic                       pwrite,
  input  logic [31:0]                paddr,
  input  logic [NCH-1:0][CNT_W-1:0]  load_all,
  input  logic [NCH-1:0][CNT_W-1:0]  cnt_all,
  input  logic [NCH-1:0][2:0]        ctrl_all,
  input  logic [NCH-1:0]             pend_vec,
  input  logic [NCH-1:0]             mask_vec,
  output logic [NCH-1:0]             wr_load,
  output logic [NCH-1:0]             wr_ctrl,
  output logic [NCH-1:0]             clr_rd,
  output logic [31:0]                prdata
);

  localparam int unsigned CH_BYTES = NCH * CH_STRIDE;
  localparam int unsigned ADDR_W   = $clog2(CH_BYTES + CH_STRIDE);
  localparam int unsigned IDX_W    = (NCH > 1) ? $clog2(NCH) : 1;

  logic [ADDR_W-1:0] off;
  logic              in_window;
  logic              in_chans;
  logic [IDX_W-1:0]  idx;
  chan_sel_e         sel;
  logic              acc_wr;
  logic              acc_rd;
  logic [31:0]       rd_mux;

  always_comb begin
    off       = paddr[ADDR_W-1:0];
    in_window = (paddr[31:ADDR_W] == '0) && (paddr[1:0] == 2'b00);
    in_chans  = in_window && (32'(off) < CH_BYTES);
    idx       = off[4 +: IDX_W];
    sel       = chan_sel_e'(off[3:2]);
    acc_wr    = psel && penable && pwrite;
    acc_rd    = psel && penable && !pwrite;
  end

  for (genvar i = 0; i < NCH; i++) begin : g_strobe
    logic here;
    assign here       = in_chans && (idx == IDX_W'(i));
    assign wr_load[i] = acc_wr && here && (sel == SEL_LOAD);
    assign wr_ctrl[i] = acc_wr && here && (sel == SEL_CTRL);
    assign clr_rd[i]  = acc_rd && here && (sel == SEL_CLEAR);
  end

  always_comb begin
    rd_mux = '0;
    if (in_chans) begin
      case (sel)
        SEL_LOAD:  rd_mux = 32'(load_all[idx]);
        SEL_VALUE: rd_mux = 32'(cnt_all[idx]);
        SEL_CTRL:  rd_mux = 32'(ctrl_all[idx]);
        SEL_CLEAR: rd_mux = 32'(pend_vec[idx]);
        default:   rd_mux = '0;
      endcase
    end else if (in_window) begin
      if (32'(off) == CH_BYTES + SH_MASKED) rd_mux = 32'(pend_vec & ~mask_vec);
      else if (32'(off) == CH_BYTES + SH_RAW) rd_mux = 32'(pend_vec);
    end
  end

  // read data is captured in the setup phase and held through the access phase
  always_ff @(posedge clk) begin
    if (rst)                             prdata <= '0;
    else if (psel && !penable && !pwrite) prdata <= rd_mux;
  end

endmodule

// File: rtl/apb_countdown_bank.sv
module apb_countdown_bank
  import cdt_pkg::*;
#(
  parameter int unsigned NCH   = 8,
  parameter int unsigned CNT_W = 32
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           psel,
  input  logic           penable,
  input  logic           pwrite,
  input  logic [31:0]    paddr,
  input  logic [31:0]    pwdata,
  output logic [31:0]    prdata,
  output logic           pready,
  output logic [NCH-1:0] irq
);

  logic [NCH-1:0][CNT_W-1:0] load_all;
  logic [NCH-1:0][CNT_W-1:0] cnt_all;
  logic [NCH-1:0][2:0]       ctrl_all;
  logic [NCH-1:0]            pend_vec;
  logic [NCH-1:0]            mask_vec;
  logic [NCH-1:0]            en_vec;
  logic [NCH-1:0]            wr_load;
  logic [NCH-1:0]            wr_ctrl;
  logic [NCH-1:0]            clr_rd;

  assign pready = 1'b1;

  cdt_apb_decode #(.NCH(NCH), .CNT_W(CNT_W)) u_decode (
    .clk      (clk),
    .rst      (rst),
    .psel     (psel),
    .penable  (penable),
    .pwrite   (pwrite),
    .paddr    (paddr),
    .load_all (load_all),
    .cnt_all  (cnt_all),
    .ctrl_all (ctrl_all),
    .pend_vec (pend_vec),
    .mask_vec (mask_vec),
    .wr_load  (wr_load),
    .wr_ctrl  (wr_ctrl),
    .clr_rd   (clr_rd),
    .prdata   (prdata)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_chan
    ctrl_t c;
    cdt_channel #(.CNT_W(CNT_W)) u_chan (
      .clk     (clk),
      .rst     (rst),
      .wr_load (wr_load[i]),
      .wr_ctrl (wr_ctrl[i]),
      .wdata   (pwdata),
      .clr_rd  (clr_rd[i]),
      .load_q  (load_all[i]),
      .cnt_q   (cnt_all[i]),
      .ctrl_q  (c),
      .pend_q  (pend_vec[i]),
      .irq_q   (irq[i])
    );
    assign ctrl_all[i] = c;
    assign mask_vec[i] = c.mask;
    assign en_vec[i]   = c.enable;
  end

endmodule

// File: rtl/cdt_checker.sv
module cdt_checker #(
  parameter int unsigned NCH   = 8,
  parameter int unsigned CNT_W = 32
) (
  input logic                      clk,
  input logic                      rst,
  input logic [NCH-1:0]            en_vec,
  input logic [NCH-1:0]            mask_vec,
  input logic [NCH-1:0]            pend_vec,
  input logic [NCH-1:0]            irq_vec,
  input logic [NCH-1:0]            clr_vec,
  input logic [NCH-1:0][CNT_W-1:0] cnt_all
);

  assert_irq_delayed_R7: assert property (@(posedge clk) disable iff (rst)
    irq_vec == $past(pend_vec & ~mask_vec));

  for (genvar i = 0; i < NCH; i++) begin : g_chk
    assert_count_step_R2: assert property (@(posedge clk) disable iff (rst)
      ($past(en_vec[i]) && ($past(cnt_all[i]) != '0)) |-> (cnt_all[i] == $past(cnt_all[i]) - 1'b1));

    assert_freeze_R9: assert property (@(posedge clk) disable iff (rst)
      (!$past(en_vec[i]) && !en_vec[i]) |-> $stable(cnt_all[i]));

    assert_pend_set_R5: assert property (@(posedge clk) disable iff (rst)
      $rose(pend_vec[i]) |-> ($past(en_vec[i]) && ($past(cnt_all[i]) == '0)));

    assert_pend_clear_R8: assert property (@(posedge clk) disable iff (rst)
      $fell(pend_vec[i]) |-> $past(clr_vec[i]));

    assert_mask_quiet_R6: assert property (@(posedge clk) disable iff (rst)
      irq_vec[i] |-> !$past(mask_vec[i]));
  end

endmodule

bind apb_countdown_bank cdt_checker #(.NCH(NCH), .CNT_W(CNT_W)) u_checker (
  .clk      (clk),
  .rst      (rst),
  .en_vec   (en_vec),
  .mask_vec (mask_vec),
  .pend_vec (pend_vec),
  .irq_vec  (irq),
  .clr_vec  (clr_rd),
  .cnt_all  (cnt_all)
);

// File: tb/apb_countdown_bank_bench.sv
module apb_countdown_bank_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 8;
  localparam int CNT_W = 32;
  localparam logic [31:0] SH = 32'(NCH * 16);

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [31:0]    paddr = '0, pwdata = '0;
  logic [31:0]    prdata;
  logic           pready;
  logic [NCH-1:0] irq;

  apb_countdown_bank #(.NCH(NCH), .CNT_W(CNT_W)) u_apb_countdown_bank (
    .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;
  logic [31:0] last_rd = '0;

  // scoreboard queues filled by the driver, drained by the monitor
  logic [31:0] exp_q[$];
  bit          chk_q[$];
  string       tag_q[$];

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  // monitor: compares read data in the access phase
  always @(negedge clk) begin
    if (!rst && psel && penable && !pwrite) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "scoreboard empty", prdata, '0);
      end else begin
        logic [31:0] e;
        bit c;
        string t;
        e = exp_q.pop_front();
        c = chk_q.pop_front();
        t = tag_q.pop_front();
        last_rd = prdata;
        if (c) check(prdata === e, t, prdata, e);
      end
    end
  end

  task automatic apb_write(input logic [31:0] a, input logic [31:0] d);
    psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = d;
    @(posedge clk); #1 penable = 1;
    @(posedge clk); #1 psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic apb_read(input logic [31:0] a, input logic [31:0] e, input bit c, input string t);
    exp_q.push_back(e); chk_q.push_back(c); tag_q.push_back(t);
    psel = 1; penable = 0; pwrite = 0; paddr = a;
    @(posedge clk); #1 penable = 1;
    @(posedge clk); #1 psel = 0; penable = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic irq_check(input logic [NCH-1:0] e, input string t);
    @(negedge clk);
    check(irq === e, t, 32'(irq), 32'(e));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "watchdog expired", '0, 32'd1);
    finish_run();
  end

  initial begin
    logic [31:0] held;
    repeat (4) @(posedge clk);
    #1 rst = 0;

    // R1 reset state, R11 pready
    @(negedge clk);
    check(irq === '0, "R1 irq after reset", 32'(irq), '0);
    check(prdata === '0, "R1 prdata after reset", prdata, '0);
    check(pready === 1'b1, "R11 pready high", 32'(pready), 32'd1);
    apb_read(32'h08, 32'h0, 1, "R1 ctrl ch0 reset");
    apb_read(32'h00, 32'h0, 1, "R1 load ch0 reset");
    apb_read(SH + 4, 32'h0, 1, "R1 raw status reset");

    // R11 undefined addresses read zero
    apb_read(SH + 32'hC, 32'h0, 1, "R11 undefined shared slot");
    apb_read(32'h1000_0000, 32'h0, 1, "R11 out of window");
    apb_read(32'h02, 32'h0, 1, "R11 misaligned");

    // ch0 free-running, load 5
    apb_write(32'h00, 32'd5);
    apb_write(32'h08, 32'h1);
    apb_read(32'h04, 32'd5, 1, "R2 count starts at load");
    idle(3);
    apb_read(32'h04, 32'd0, 1, "R2 count reached zero");
    apb_read(32'h04, 32'hFFFF_FFFE, 1, "R3 free reload all ones");
    apb_read(SH + 4, 32'h1, 1, "R5 raw bit0 set");
    irq_check(8'h01, "R7 irq0 follows pending");
    apb_read(SH, 32'h1, 1, "R6 masked status unmasked ch0");
    apb_read(32'h0C, 32'h1, 1, "R8 clear read returns pending");
    apb_read(SH + 4, 32'h0, 1, "R8 raw cleared");
    irq_check(8'h00, "R8 irq0 dropped");
    apb_read(32'h08, 32'h1, 1, "R8 ctrl unchanged by clear");

    // R9 freeze
    apb_write(32'h08, 32'h0);
    apb_read(32'h04, 32'h0, 0, "R9 sample");
    held = last_rd;
    idle(3);
    apb_read(32'h04, held, 1, "R9 ch0 frozen");

    // ch1 periodic masked, load 3
    apb_write(32'h10, 32'd3);
    apb_write(32'h18, 32'h7);
    idle(4);
    apb_read(32'h14, 32'd3, 1, "R4 periodic reload of load");
    irq_check(8'h00, "R6 masked irq low");
    apb_read(SH + 4, 32'h2, 1, "R6 raw set while masked");
    apb_read(SH, 32'h0, 1, "R6 masked status hides ch1");
    apb_write(32'h18, 32'h3);
    idle(1);
    irq_check(8'h02, "R7 irq1 after unmask");
    apb_read(SH, 32'h2, 1, "R6 masked status after unmask");

    apb_write(32'h18, 32'h0);
    apb_read(32'h14, 32'h0, 0, "R9 sample");
    held = last_rd;
    idle(2);
    apb_read(32'h14, held, 1, "R9 ch1 frozen");
    apb_read(SH + 4, 32'h2, 1, "R9 pending kept when disabled");

    // ch2 periodic, load changed while running
    apb_write(32'h20, 32'd4);
    apb_write(32'h28, 32'h3);
    apb_write(32'h20, 32'd9);
    apb_read(32'h24, 32'd2, 1, "R10 running count untouched");
    apb_read(32'h24, 32'd0, 1, "R10 count at zero");
    apb_read(32'h24, 32'd8, 1, "R10 new load used at reload");
    apb_read(32'h20, 32'd9, 1, "R10 load register holds new value");

    // R12 isolation, R11 write to read-only ignored
    apb_read(32'h30, 32'h0, 1, "R12 ch3 load untouched");
    apb_read(32'h38, 32'h0, 1, "R12 ch3 ctrl untouched");
    apb_read(SH + 4, 32'h6, 1, "R12 raw only ch1 ch2");
    apb_write(SH, 32'hFF);
    apb_read(SH, 32'h6, 1, "R11 write to status ignored");

    idle(2);
    if (exp_q.size() != 0) check(1'b0, "scoreboard leftover", 32'(exp_q.size()), '0);
    finish_run();
  end

endmodule